// File: doc/BRIEF.md
# Serial Receive FIFO Interrupt Controller

This block is the register and interrupt slice of a byte-oriented serial port. A host reaches it over a simple register bus to program a mode byte, a bit-rate byte and a control byte. It also writes bytes to send. Bytes to send leave on a one-cycle output strobe. Bytes that arrive on a receive strobe are queued in a 16-entry FIFO, which the host drains by reading one offset. The block does not shift bits, derive baud timing, or handle framing errors or line breaks.

The receive interrupt fires in one of two cases. The first is when the FIFO fill reaches a trigger level chosen by the mode register. The second is when a FIFO holding fewer bytes than the trigger has gone 15 character units without a new byte. The character unit is a parameter counted in clock cycles. Its default is one bit time at 9600 baud with a 200 MHz clock. Writes to the control byte act on the interrupt lines and the transmit-end flag at once.

Top module: `serial_rxint_ctrl`

## Requirements
- R1: After reset, rx_irq, tx_irq and tx_valid are 0. Mode, bit-rate, control and fill count read 0. The status byte reads 0x06, where status bit 0 is receive-data-full, bit 1 is transmit-data-empty and bit 2 is transmit-end.
- R2: Writes to offset 0x00 (mode) and 0x04 (bit rate) store the full byte. A read presents the stored byte on bus_rdata one cycle after the read strobe.
- R3: With FIFO_MODE=1, a write to offset 0x08 (control) stores the byte ANDed with 0xFA. With FIFO_MODE=0 it stores the full byte.
- R4: A control write with bit 5 clear sets both transmit-end and transmit-data-empty in the status byte at offset 0x10.
- R5: With FIFO_MODE=1, tx_irq takes the value of control bit 7 in the cycle after a control write.
- R6: A control write with bit 6 clear drives rx_irq low in the next cycle.
- R7: A write to offset 0x0C raises tx_valid for exactly one cycle, with tx_byte equal to the written byte. The byte can be read back at 0x0C. The write clears transmit-data-empty and transmit-end.
- R8: A byte taken on rx_valid is queued in arrival order. Each read of offset 0x14 returns and removes the oldest byte. Offset 0x18 returns the fill count. A read of 0x14 on an empty FIFO returns 0 and leaves the count at 0.
- R9: The FIFO holds 16 bytes. A byte that arrives while it is full is dropped, and both the count and the queued data stay unchanged.
- R10: Mode bits [1:0] select the trigger level: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14. When a byte brings the fill to at least this level, receive-data-full is set at the same edge. rx_irq also rises at that edge if control bit 6 is set.
- R11: A byte that leaves the fill below the trigger restarts a timeout of 15*ETU_CYCLES cycles. On expiry, receive-data-full is set, and rx_irq rises if control bit 6 is set. A later byte starts the timeout again from its full length.
- R12: Reaching the trigger level while control bit 6 is set cancels any pending timeout.
- R13: A read that empties the FIFO clears receive-data-full and rx_irq and stops the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| rx_irq | output | 1 | Receive interrupt |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
The hardest case to reach from the ports is the timeout that was cancelled or stopped. A cancelled timeout leaves nothing at the outputs, so the bench has to rebuild a state in which an uncancelled timer would show up. It reaches the trigger with the interrupt enabled, drops the enable, then turns it back on and waits past the full timeout while rx_irq must stay low. The bench checks the stop-on-drain path the same way: it pushes one byte, reads it back out, and waits a full timeout. The expiry edge itself is checked by counting cycles from the push edge to one cycle before expiry and to the expiry edge, with a short unit length set by parameter.

// File: rtl/sric_pkg.sv
package sric_pkg;
  typedef logic [7:0] byte_t;
  localparam byte_t OFS_MODE = 8'h00;
  localparam byte_t OFS_BRR  = 8'h04;
  localparam byte_t OFS_CTRL = 8'h08;
  localparam byte_t OFS_TXD  = 8'h0C;
  localparam byte_t OFS_STAT = 8'h10;
  localparam byte_t OFS_RXD  = 8'h14;
  localparam byte_t OFS_CNT  = 8'h18;
  localparam int CTRL_TIE = 7;
  localparam int CTRL_RIE = 6;
  localparam int CTRL_TE  = 5;
endpackage

// File: rtl/sric_fifo.sv
module sric_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop_ok)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  p_drop_full_r9: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (count == $past(count)));
  p_pop_empty_r8: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/sric_timeout.sv
module sric_timeout #(
  parameter int LIMIT = 312495,
  localparam int TW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic stop,
  output logic expire
);
  logic [TW-1:0] cnt;

  assign expire = (cnt == TW'(1));

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= TW'(LIMIT);
    else if (stop)        cnt <= '0;
    else if (cnt != '0)   cnt <= cnt - TW'(1);
  end

  p_bounded_r11: assert property (@(posedge clk) disable iff (rst)
    cnt <= TW'(LIMIT));
  p_expire_once_r11: assert property (@(posedge clk) disable iff (rst)
    (expire && !load) |=> !expire);
  p_stop_r13: assert property (@(posedge clk) disable iff (rst)
    (stop && !load) |=> (cnt == '0));
endmodule

// File: rtl/sric_trig.sv
module sric_trig #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [1:0]       sel,
  output logic [CNT_W-1:0] level
);
  function automatic logic [CNT_W-1:0] clamp(input int v);
    if (v > DEPTH) return CNT_W'(DEPTH);
    return CNT_W'(v);
  endfunction

  always_comb begin
    case (sel)
      2'd0:    level = clamp(1);
      2'd1:    level = clamp(4);
      2'd2:    level = clamp(8);
      default: level = clamp(14);
    endcase
  end
endmodule

// File: rtl/serial_rxint_ctrl.sv
module serial_rxint_ctrl
  import sric_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int ETU_CYCLES = 20833,
  parameter int TO_UNITS   = 15,
  parameter bit FIFO_MODE  = 1'b1,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1),
  localparam int TO_CYCLES = TO_UNITS * ETU_CYCLES
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic       tx_valid,
  output logic [7:0] tx_byte,
  output logic       rx_irq,
  output logic       tx_irq
);
  localparam byte_t CTRL_MASK = FIFO_MODE ? 8'hFA : 8'hFF;

  byte_t mode_q, brr_q, ctrl_q, tdr_q;
  logic  rdf_q, tde_q, tend_q;

  logic wr_mode, wr_brr, wr_ctrl, wr_tx, rd_pop;
  logic [7:0]       head;
  logic [CNT_W-1:0] count, trig;
  logic full, empty, push_ok, pop_ok, hit, below, drain, expire;
  logic rie, tmr_stop;

  assign wr_mode = bus_wr && (bus_addr == OFS_MODE);
  assign wr_brr  = bus_wr && (bus_addr == OFS_BRR);
  assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_tx   = bus_wr && (bus_addr == OFS_TXD);
  assign rd_pop  = bus_rd && (bus_addr == OFS_RXD);

  sric_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst(rst), .push(rx_valid), .din(rx_byte), .pop(rd_pop),
    .head(head), .count(count), .full(full), .empty(empty)
  );

  sric_trig #(.DEPTH(FIFO_DEPTH)) u_trig (.sel(mode_q[1:0]), .level(trig));

  assign rie     = ctrl_q[CTRL_RIE];
  assign push_ok = rx_valid && !full;
  assign pop_ok  = rd_pop && !empty;
  assign hit     = push_ok && ((count + CNT_W'(1)) >= trig);
  assign below   = push_ok && !hit;
  assign drain   = pop_ok && !push_ok && (count == CNT_W'(1));
  assign tmr_stop = (hit && rie) || drain;

  sric_timeout #(.LIMIT(TO_CYCLES)) u_tmo (
    .clk(clk), .rst(rst), .load(below), .stop(tmr_stop), .expire(expire)
  );

  // register file and transmit side
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      brr_q    <= '0;
      ctrl_q   <= '0;
      tdr_q    <= '0;
      tde_q    <= 1'b1;
      tend_q   <= 1'b1;
      tx_valid <= 1'b0;
      tx_byte  <= '0;
      tx_irq   <= 1'b0;
    end else begin
      tx_valid <= wr_tx;
      if (wr_mode) mode_q <= bus_wdata;
      if (wr_brr)  brr_q  <= bus_wdata;
      if (wr_tx) begin
        tdr_q   <= bus_wdata;
        tx_byte <= bus_wdata;
        tde_q   <= 1'b0;
        tend_q  <= 1'b0;
      end
      if (wr_ctrl) begin
        ctrl_q <= bus_wdata & CTRL_MASK;
        if (FIFO_MODE) tx_irq <= bus_wdata[CTRL_TIE];
        if (!bus_wdata[CTRL_TE]) begin
          tde_q  <= 1'b1;
          tend_q <= 1'b1;
        end
      end
    end
  end

  // receive-data-full flag and receive interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      rdf_q  <= 1'b0;
      rx_irq <= 1'b0;
    end else begin
      if (drain)               rdf_q <= 1'b0;
      else if (hit || expire)  rdf_q <= 1'b1;
      if (wr_ctrl && !bus_wdata[CTRL_RIE]) rx_irq <= 1'b0;
      else if (drain)                      rx_irq <= 1'b0;
      else if ((hit || expire) && rie)     rx_irq <= 1'b1;
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        OFS_MODE: bus_rdata <= mode_q;
        OFS_BRR:  bus_rdata <= brr_q;
        OFS_CTRL: bus_rdata <= ctrl_q;
        OFS_TXD:  bus_rdata <= tdr_q;
        OFS_STAT: bus_rdata <= {5'b0, tend_q, tde_q, rdf_q};
        OFS_RXD:  bus_rdata <= empty ? 8'h00 : head;
        OFS_CNT:  bus_rdata <= 8'(count);
        default:  bus_rdata <= '0;
      endcase
    end
  end

  p_tx_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    wr_tx |=> (tx_valid && tx_byte == $past(bus_wdata)));
  p_tx_single_r7: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !$past(wr_tx)) |-> 1'b0);
  p_txirq_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && FIFO_MODE) |=> (tx_irq == $past(bus_wdata[CTRL_TIE])));
  p_rie_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !bus_wdata[CTRL_RIE]) |=> !rx_irq);
  p_tend_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !bus_wdata[CTRL_TE]) |=> (tend_q && tde_q));
  p_irq_needs_rdf_r10: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> rdf_q);
  p_drain_r13: assert property (@(posedge clk) disable iff (rst)
    drain |=> (!rdf_q && !rx_irq));
endmodule

// File: tb/serial_rxint_ctrl_test.sv
module serial_rxint_ctrl_test;
  localparam int ETU = 2;
  localparam int TO  = 15 * ETU;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0, rx_valid = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, rx_byte = 0;
  logic [7:0] bus_rdata, tx_byte;
  logic tx_valid, rx_irq, tx_irq;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_rxint_ctrl #(.FIFO_DEPTH(16), .ETU_CYCLES(ETU), .TO_UNITS(15), .FIFO_MODE(1'b1)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

  task automatic check(input string tag, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int trig_of(input int sel);
    case (sel)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic drain_all();
    logic [7:0] d;
    rd(8'h18, d);
    for (int i = 0; i < int'(d); i++) begin
      logic [7:0] x;
      rd(8'h14, x);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] q[$];
    void'($urandom(32'd4321));
    idle(3); rst = 0; idle(1);

    // R1 reset state
    check("R1 rx_irq", rx_irq, 0);
    check("R1 tx_irq", tx_irq, 0);
    check("R1 tx_valid", tx_valid, 0);
    rd(8'h00, d); check("R1 mode", d, 0);
    rd(8'h04, d); check("R1 brr", d, 0);
    rd(8'h08, d); check("R1 ctrl", d, 0);
    rd(8'h10, d); check("R1 status", d, 8'h06);
    rd(8'h18, d); check("R1 count", d, 0);

    // R2 mode and bit rate
    wr(8'h00, 8'h5D); rd(8'h00, d); check("R2 mode", d, 8'h5D);
    wr(8'h04, 8'h81); rd(8'h04, d); check("R2 brr", d, 8'h81);

    // R3 / R5 control mask and tx_irq
    wr(8'h08, 8'hFF);
    check("R5 tx_irq high", tx_irq, 1);
    rd(8'h08, d); check("R3 ctrl mask", d, 8'hFA);

    // R7 transmit write
    wr(8'h0C, 8'h3C);
    check("R7 tx_valid", tx_valid, 1);
    check("R7 tx_byte", tx_byte, 8'h3C);
    @(negedge clk); check("R7 tx_valid pulse", tx_valid, 0);
    rd(8'h10, d); check("R7 status", d, 8'h00);
    rd(8'h0C, d); check("R7 readback", d, 8'h3C);

    // R4 transmit disable sets flags, R5 tx_irq low, R3 mask
    wr(8'h08, 8'h47);
    check("R5 tx_irq low", tx_irq, 0);
    rd(8'h10, d); check("R4 status", d, 8'h06);
    rd(8'h08, d); check("R3 ctrl mask2", d, 8'h42);

    // R10 trigger at 4, rie set
    for (int i = 0; i < 3; i++) begin
      push(8'h10 + 8'(i));
      check("R10 below trigger", rx_irq, 0);
    end
    push(8'h13);
    check("R10 trigger irq", rx_irq, 1);
    rd(8'h10, d); check("R10 rdf", d & 1, 1);
    // R6 clear rie
    wr(8'h08, 8'h22); check("R6 rie clear", rx_irq, 0);
    // R12 re-enable and wait past timeout
    wr(8'h08, 8'h62); idle(TO + 5);
    check("R12 cancelled", rx_irq, 0);
    // R8 order
    for (int i = 0; i < 4; i++) begin
      rd(8'h14, d); check("R8 order", d, 8'h10 + i);
    end
    rd(8'h10, d); check("R13 rdf cleared", d & 1, 0);
    rd(8'h14, d); check("R8 empty read", d, 0);
    rd(8'h18, d); check("R8 empty count", d, 0);

    // R11 timeout
    push(8'hA1);
    idle(TO - 1); check("R11 before expiry", rx_irq, 0);
    idle(1);      check("R11 expiry", rx_irq, 1);
    rd(8'h10, d); check("R11 rdf", d & 1, 1);
    rd(8'h14, d); check("R8 data", d, 8'hA1);
    check("R13 irq cleared", rx_irq, 0);
    rd(8'h10, d); check("R13 rdf clear", d & 1, 0);
    // R11 restart
    push(8'hB1); idle(10); push(8'hB2);
    idle(TO - 1); check("R11 restart before", rx_irq, 0);
    idle(1);      check("R11 restart expiry", rx_irq, 1);
    drain_all();
    check("R13 drained irq", rx_irq, 0);
    // R13 stop on drain
    push(8'hC1); rd(8'h14, d); idle(TO + 5);
    check("R13 timer stopped", rx_irq, 0);
    rd(8'h10, d); check("R13 rdf stays", d & 1, 0);

    // R10 other levels
    for (int s = 0; s < 4; s++) begin
      wr(8'h00, 8'(s));
      for (int i = 0; i < trig_of(s) - 1; i++) push(8'(i));
      check("R10 level not reached", rx_irq, 0);
      push(8'hEE);
      check("R10 level reached", rx_irq, 1);
      drain_all();
      check("R13 level drain", rx_irq, 0);
    end

    // R9 full
    wr(8'h08, 8'h20);
    for (int i = 0; i < 17; i++) push(8'h40 + 8'(i));
    rd(8'h18, d); check("R9 count full", d, 16);
    for (int i = 0; i < 16; i++) begin
      rd(8'h14, d); check("R9 order", d, 8'h40 + i);
    end
    rd(8'h18, d); check("R9 count empty", d, 0);

    // random mix against a queue model (R8, R9, R7)
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 9);
      logic [7:0] v = 8'($urandom);
      if (op < 5) begin
        push(v);
        if (q.size() < 16) q.push_back(v);
      end else if (op < 8) begin
        rd(8'h14, d);
        if (q.size() == 0) check("R8 rand empty", d, 0);
        else check("R8 rand pop", d, q.pop_front());
      end else if (op == 8) begin
        wr(8'h0C, v);
        check("R7 rand tx", tx_byte, v);
      end else begin
        rd(8'h18, d); check("R9 rand count", d, q.size());
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule